// File: doc/BRIEF.md
# Multidrop Addressed Command Decoder

This block sits behind a 9-bit serial receiver on a link shared by up to 32 boards. Each received character arrives with a ninth bit. When that bit is clear the character is a command. When it is set the character is a payload byte for the command in progress. A command byte holds a 3-bit opcode in bits 7:5 and a 5-bit field in bits 4:0. The 5-bit field is either a board address or a small argument. Four opcodes act on every board on the link. The other four act only on the board whose strap-set identity matches the field.

The decoder updates a set of configuration registers: the look-ahead limit, a 2-bit difficulty and one 5-bit clock setting per chip. It collects fixed-length job payloads and raises single-cycle control pulses for the surrounding logic: job reset, job accepted, per-chip reset, reboot, test-report request and result pop. It also queues one-byte replies on a valid/ready stream, so the transmitter can stall it. All pulses and register updates become visible one clock after the received-byte strobe.

Top module: `mdrop_cmd_decoder`

## Requirements
- R1: A character is a command only when `rx_bit9` is 0, and a payload byte only when `rx_bit9` is 1. A payload byte that arrives while no capture is open changes no output.
- R2: Bits 7:5 of a command select the opcode: 0 reboot, 1 long poll, 2 clock-all, 3 difficulty, 4 job, 5 ask, 6 test report, 7 per-chip clock. Opcodes 0 to 3 execute whatever bits 4:0 hold. Opcodes 4 to 7 execute only when bits 4:0 equal `board_id`, and otherwise produce no pulse and no reply.
- R3: Long poll sets `lookahead_o` to 10 + 10 x (bits 4:0) and pulses `job_reset_o`.
- R4: Clock-all writes bits 4:0 into every chip clock setting and pulses `job_reset_o`.
- R5: Difficulty stores only bits 1:0 of the argument.
- R6: Ask queues one reply byte. The byte is 0x5A, with a `result_pop_o` pulse, when `fifo_nonempty` is 1. Otherwise it is 0xA6 when `job_busy` is 1, else 0x56.
- R7: Job captures `JOB_LEN` payload bytes. Payload byte k lands in `job_data_o[8k+7:8k]`. After the last byte the block pulses `job_accept_o` and queues reply 0x58.
- R8: A command character that arrives during any payload capture ends that capture without an accept and is decoded as a new command.
- R9: Per-chip clock reads a sub-command byte: bits 7:5 give the mode and bits 4:0 give the chip. Mode 0 then takes `NUM_CHIPS` values that are written to chips 0 upward in order, with a `job_reset_o` pulse after the last one.
- R10: Mode 1 takes one value, writes it to the selected chip and also pulses `chip_reset_o` for that chip. Mode 2 pulses `chip_reset_o` for the selected chip and changes no clock setting. Every clock value taken from the link is masked to its low 5 bits.
- R11: Replies leave in order on `tx_valid`/`tx_ready`. While `tx_ready` is low, `tx_valid` and `tx_data` hold.
- R12: After reset, all pulses are 0, `tx_valid` is 0, `lookahead_o` is 10, `difficulty_o` is 0 and every chip clock setting is `CLK_RST`. Pulses and reply bytes appear one clock after the strobe that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character, low 8 bits |
| rx_bit9 | input | 1 | Ninth bit: 0 command, 1 payload |
| board_id | input | 5 | Local board identity |
| fifo_nonempty | input | 1 | Result FIFO holds at least one record |
| job_busy | input | 1 | Chips still working on the current job |
| tx_valid | output | 1 | Reply byte available |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Transmitter takes the reply byte |
| job_reset_o | output | 1 | Pulse: clear job state and FIFO pointers |
| job_accept_o | output | 1 | Pulse: `job_data_o` holds a complete job |
| job_data_o | output | 8*JOB_LEN | Captured job payload, byte 0 lowest |
| reboot_o | output | 1 | Pulse: reboot request |
| report_req_o | output | 1 | Pulse: send test report |
| result_pop_o | output | 1 | Pulse: stream one result record after 0x5A |
| chip_reset_o | output | 1 | Pulse: reset one chip |
| chip_reset_idx_o | output | 5 | Chip addressed by the last chip reset |
| lookahead_o | output | 9 | Look-ahead limit |
| difficulty_o | output | 2 | Difficulty setting |
| chip_clk_o | output | 5*NUM_CHIPS | Clock setting per chip, chip 0 lowest |

## Verification
The bench targets addressing at the boundary between opcode 3 and opcode 4. A decoder that compared the board field for every opcode would miss a foreign reboot or clock-all, and one that never compared it would answer another board's ask. It ends a job capture midway with a command character and then sends a fresh job. A design that kept the stale byte count would accept early or never accept, and one that treated the interrupting character as payload would lose the command. It also checks that mode 1 resets the chip it reclocks and that mode 2 leaves every clock setting alone. Finally, it stalls the reply stream across two queued answers, so reordered or dropped bytes show up.

// File: rtl/mdc_pkg.sv
package mdc_pkg;
  localparam int ARG_W = 5;
  localparam int LA_W  = 9;

  typedef enum logic [2:0] {
    OP_REBOOT  = 3'd0,
    OP_LPOLL   = 3'd1,
    OP_GCLK    = 3'd2,
    OP_DIFF    = 3'd3,
    OP_JOB     = 3'd4,
    OP_ASK     = 3'd5,
    OP_REPORT  = 3'd6,
    OP_CHIPCLK = 3'd7
  } op_e;

  localparam logic [2:0] SUB_ALL = 3'd0;
  localparam logic [2:0] SUB_ONE = 3'd1;
  localparam logic [2:0] SUB_RST = 3'd2;

  localparam logic [7:0] RPL_RESULT = 8'h5A;
  localparam logic [7:0] RPL_READY  = 8'h56;
  localparam logic [7:0] RPL_BUSY   = 8'hA6;
  localparam logic [7:0] RPL_JOBACK = 8'h58;

  function automatic logic [LA_W-1:0] lookahead_of(input logic [ARG_W-1:0] a);
    logic [LA_W-1:0] ext;
    ext = LA_W'(a);
    return (ext << 3) + (ext << 1) + LA_W'(10);
  endfunction

  function automatic logic [7:0] ask_code(input logic have_result, input logic busy);
    if (have_result) return RPL_RESULT;
    return busy ? RPL_BUSY : RPL_READY;
  endfunction
endpackage

// File: rtl/mdc_filter.sv
module mdc_filter
  import mdc_pkg::*;
(
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_bit9,
  input  logic [ARG_W-1:0] board_id,
  output logic             cmd_seen,
  output logic             cmd_hit,
  output op_e              op,
  output logic [ARG_W-1:0] arg,
  output logic             pay_seen
);
  logic broadcast;

  always_comb begin
    op        = op_e'(rx_data[7:5]);
    arg       = rx_data[ARG_W-1:0];
    broadcast = ~rx_data[7];
    cmd_seen  = rx_valid & ~rx_bit9;
    pay_seen  = rx_valid & rx_bit9;
    cmd_hit   = cmd_seen & (broadcast | (arg == board_id));
  end
endmodule

// File: rtl/mdc_seq.sv
module mdc_seq
  import mdc_pkg::*;
#(
  parameter int JOB_LEN   = 49,
  parameter int NUM_CHIPS = 32,
  localparam int SPAN  = (JOB_LEN > NUM_CHIPS) ? JOB_LEN : NUM_CHIPS,
  localparam int CNT_W = $clog2(SPAN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_seen,
  input  logic             cmd_hit,
  input  op_e              op,
  input  logic             pay_seen,
  input  logic [7:0]       pay_byte,
  output logic             ev_reboot,
  output logic             ev_lpoll,
  output logic             ev_gclk,
  output logic             ev_diff,
  output logic             ev_ask,
  output logic             ev_report,
  output logic             ev_job_wr,
  output logic [CNT_W-1:0] job_idx,
  output logic             ev_job_done,
  output logic             ev_clk_wr,
  output logic [ARG_W-1:0] clk_idx,
  output logic             ev_all_done,
  output logic             ev_chip_rst,
  output logic [ARG_W-1:0] chip_idx
);
  typedef enum logic [2:0] {S_IDLE, S_JOB, S_SUB, S_ALL, S_ONE} st_e;

  st_e              st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [ARG_W-1:0] chip_q, chip_n;
  logic             sub_in_range, sel_in_range;

  assign sub_in_range = int'(pay_byte[ARG_W-1:0]) < NUM_CHIPS;
  assign sel_in_range = int'(chip_q) < NUM_CHIPS;

  always_comb begin
    st_n        = st_q;
    cnt_n       = cnt_q;
    chip_n      = chip_q;
    ev_reboot   = 1'b0;
    ev_lpoll    = 1'b0;
    ev_gclk     = 1'b0;
    ev_diff     = 1'b0;
    ev_ask      = 1'b0;
    ev_report   = 1'b0;
    ev_job_wr   = 1'b0;
    ev_job_done = 1'b0;
    ev_clk_wr   = 1'b0;
    ev_all_done = 1'b0;
    ev_chip_rst = 1'b0;
    job_idx     = cnt_q;
    clk_idx     = (st_q == S_ALL) ? ARG_W'(cnt_q) : chip_q;
    chip_idx    = (st_q == S_SUB) ? pay_byte[ARG_W-1:0] : chip_q;
    if (cmd_seen) begin
      st_n  = S_IDLE;
      cnt_n = '0;
      if (cmd_hit) begin
        unique case (op)
          OP_REBOOT:  ev_reboot = 1'b1;
          OP_LPOLL:   ev_lpoll  = 1'b1;
          OP_GCLK:    ev_gclk   = 1'b1;
          OP_DIFF:    ev_diff   = 1'b1;
          OP_JOB:     st_n      = S_JOB;
          OP_ASK:     ev_ask    = 1'b1;
          OP_REPORT:  ev_report = 1'b1;
          OP_CHIPCLK: st_n      = S_SUB;
          default:    st_n      = S_IDLE;
        endcase
      end
    end else if (pay_seen) begin
      unique case (st_q)
        S_JOB: begin
          ev_job_wr = 1'b1;
          if (cnt_q == CNT_W'(JOB_LEN - 1)) begin
            ev_job_done = 1'b1;
            st_n        = S_IDLE;
            cnt_n       = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        S_SUB: begin
          chip_n = pay_byte[ARG_W-1:0];
          cnt_n  = '0;
          if (pay_byte[7:5] == SUB_ALL) begin
            st_n = S_ALL;
          end else if (pay_byte[7:5] == SUB_ONE) begin
            st_n = S_ONE;
          end else begin
            ev_chip_rst = (pay_byte[7:5] == SUB_RST) && sub_in_range;
            st_n        = S_IDLE;
          end
        end
        S_ALL: begin
          ev_clk_wr = 1'b1;
          if (cnt_q == CNT_W'(NUM_CHIPS - 1)) begin
            ev_all_done = 1'b1;
            st_n        = S_IDLE;
            cnt_n       = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        S_ONE: begin
          ev_clk_wr   = sel_in_range;
          ev_chip_rst = sel_in_range;
          st_n        = S_IDLE;
        end
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      chip_q <= '0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      chip_q <= chip_n;
    end
  end

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_reboot, ev_lpoll, ev_gclk, ev_diff, ev_ask, ev_report, ev_job_done, ev_all_done})); // R2
  AST_CAPTURE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_seen && st_q != S_IDLE && !(cmd_hit && (op == OP_JOB || op == OP_CHIPCLK)))
      |=> (st_q == S_IDLE)); // R8
  AST_IDLE_PAYLOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_seen && st_q == S_IDLE) |-> !(ev_job_wr || ev_clk_wr || ev_chip_rst)); // R1
endmodule

// File: rtl/mdc_reply_fifo.sv
module mdc_reply_fifo #(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [7:0] push_data,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready
);
  logic [7:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [PTR_W:0]   count_q;
  logic           pop, full, take;

  assign tx_valid = (count_q != '0);
  assign tx_data  = mem_q[rp_q];
  assign pop      = tx_valid & tx_ready;
  assign full     = (count_q == (PTR_W+1)'(DEPTH));
  assign take     = push & (~full | pop);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (take) mem_q[wp_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q    <= '0;
      rp_q    <= '0;
      count_q <= '0;
    end else begin
      if (take) wp_q <= bump(wp_q);
      if (pop)  rp_q <= bump(rp_q);
      count_q <= count_q + (PTR_W+1)'(take) - (PTR_W+1)'(pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop)); // R11
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R11
endmodule

// File: rtl/mdrop_cmd_decoder.sv
module mdrop_cmd_decoder
  import mdc_pkg::*;
#(
  parameter int          NUM_CHIPS   = 32,
  parameter int          JOB_LEN     = 49,
  parameter int          REPLY_DEPTH = 4,
  parameter logic [4:0]  CLK_RST     = 5'd0,
  localparam int SPAN  = (JOB_LEN > NUM_CHIPS) ? JOB_LEN : NUM_CHIPS,
  localparam int CNT_W = $clog2(SPAN + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rx_valid,
  input  logic [7:0]             rx_data,
  input  logic                   rx_bit9,
  input  logic [4:0]             board_id,
  input  logic                   fifo_nonempty,
  input  logic                   job_busy,
  output logic                   tx_valid,
  output logic [7:0]             tx_data,
  input  logic                   tx_ready,
  output logic                   job_reset_o,
  output logic                   job_accept_o,
  output logic [8*JOB_LEN-1:0]   job_data_o,
  output logic                   reboot_o,
  output logic                   report_req_o,
  output logic                   result_pop_o,
  output logic                   chip_reset_o,
  output logic [4:0]             chip_reset_idx_o,
  output logic [LA_W-1:0]        lookahead_o,
  output logic [1:0]             difficulty_o,
  output logic [5*NUM_CHIPS-1:0] chip_clk_o
);
  logic             cmd_seen, cmd_hit, pay_seen;
  op_e              op;
  logic [ARG_W-1:0] arg;
  logic             ev_reboot, ev_lpoll, ev_gclk, ev_diff, ev_ask, ev_report;
  logic             ev_job_wr, ev_job_done, ev_clk_wr, ev_all_done, ev_chip_rst;
  logic [CNT_W-1:0] job_idx;
  logic [ARG_W-1:0] clk_idx, chip_idx;
  logic             reply_push;
  logic [7:0]       reply_byte;

  mdc_filter u_filter (
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_bit9  (rx_bit9),
    .board_id (board_id),
    .cmd_seen (cmd_seen),
    .cmd_hit  (cmd_hit),
    .op       (op),
    .arg      (arg),
    .pay_seen (pay_seen)
  );

  mdc_seq #(.JOB_LEN(JOB_LEN), .NUM_CHIPS(NUM_CHIPS)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_seen    (cmd_seen),
    .cmd_hit     (cmd_hit),
    .op          (op),
    .pay_seen    (pay_seen),
    .pay_byte    (rx_data),
    .ev_reboot   (ev_reboot),
    .ev_lpoll    (ev_lpoll),
    .ev_gclk     (ev_gclk),
    .ev_diff     (ev_diff),
    .ev_ask      (ev_ask),
    .ev_report   (ev_report),
    .ev_job_wr   (ev_job_wr),
    .job_idx     (job_idx),
    .ev_job_done (ev_job_done),
    .ev_clk_wr   (ev_clk_wr),
    .clk_idx     (clk_idx),
    .ev_all_done (ev_all_done),
    .ev_chip_rst (ev_chip_rst),
    .chip_idx    (chip_idx)
  );

  assign reply_push = ev_ask | ev_job_done;
  assign reply_byte = ev_job_done ? RPL_JOBACK : ask_code(fifo_nonempty, job_busy);

  mdc_reply_fifo #(.DEPTH(REPLY_DEPTH)) u_reply (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (reply_push),
    .push_data (reply_byte),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      job_reset_o      <= 1'b0;
      job_accept_o     <= 1'b0;
      reboot_o         <= 1'b0;
      report_req_o     <= 1'b0;
      result_pop_o     <= 1'b0;
      chip_reset_o     <= 1'b0;
      chip_reset_idx_o <= '0;
      lookahead_o      <= LA_W'(10);
      difficulty_o     <= '0;
    end else begin
      job_reset_o  <= ev_lpoll | ev_gclk | ev_all_done;
      job_accept_o <= ev_job_done;
      reboot_o     <= ev_reboot;
      report_req_o <= ev_report;
      result_pop_o <= ev_ask & fifo_nonempty;
      chip_reset_o <= ev_chip_rst;
      if (ev_chip_rst) chip_reset_idx_o <= chip_idx;
      if (ev_lpoll)    lookahead_o      <= lookahead_of(arg);
      if (ev_diff)     difficulty_o     <= arg[1:0];
    end
  end

  for (genvar g = 0; g < NUM_CHIPS; g++) begin : g_chipclk
    logic [4:0] clk_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                    clk_q <= CLK_RST;
      else if (ev_gclk)                              clk_q <= arg;
      else if (ev_clk_wr && clk_idx == ARG_W'(g))    clk_q <= rx_data[4:0];
    end
    assign chip_clk_o[5*g +: 5] = clk_q;
  end

  for (genvar g = 0; g < JOB_LEN; g++) begin : g_jobbyte
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                    byte_q <= '0;
      else if (ev_job_wr && job_idx == CNT_W'(g))    byte_q <= rx_data;
    end
    assign job_data_o[8*g +: 8] = byte_q;
  end

  AST_LOOKAHEAD_ONLY_ON_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (lookahead_o != $past(lookahead_o)) |-> job_reset_o); // R3
  AST_ACCEPT_FROM_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    job_accept_o |-> $past(rx_valid && rx_bit9)); // R7
  AST_ASK_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_bit9 && rx_data[7:5] == 3'd5 && rx_data[4:0] == board_id && !tx_valid)
      |=> tx_valid); // R6
  AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_bit9 && rx_data[7] && rx_data[4:0] != board_id)
      |=> !(report_req_o || result_pop_o)); // R2
endmodule

// File: tb/mdrop_cmd_decoder_tb_top.sv
module mdrop_cmd_decoder_tb_top;
  localparam int NCH  = 32;
  localparam int JLEN = 49;
  localparam logic [4:0] MYID = 5'd9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_bit9 = 1'b1, fifo_nonempty = 1'b0, job_busy = 1'b0, tx_ready = 1'b1;
  logic [7:0] rx_data = '0;
  logic tx_valid, job_reset_o, job_accept_o, reboot_o, report_req_o, result_pop_o, chip_reset_o;
  logic [7:0] tx_data;
  logic [8*JLEN-1:0] job_data_o;
  logic [4:0] chip_reset_idx_o;
  logic [8:0] lookahead_o;
  logic [1:0] difficulty_o;
  logic [5*NCH-1:0] chip_clk_o;
  int runs = 0, fails = 0;

  always #4 clk = ~clk;

  mdrop_cmd_decoder #(.NUM_CHIPS(NCH), .JOB_LEN(JLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_bit9(rx_bit9),
    .board_id(MYID), .fifo_nonempty(fifo_nonempty), .job_busy(job_busy),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .job_reset_o(job_reset_o), .job_accept_o(job_accept_o), .job_data_o(job_data_o),
    .reboot_o(reboot_o), .report_req_o(report_req_o), .result_pop_o(result_pop_o),
    .chip_reset_o(chip_reset_o), .chip_reset_idx_o(chip_reset_idx_o),
    .lookahead_o(lookahead_o), .difficulty_o(difficulty_o), .chip_clk_o(chip_clk_o)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic b9, input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_bit9 = b9; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0; rx_bit9 = 1'b1;
  endtask

  // fields: b9, data, fne, busy, exp reboot, exp job_reset, exp report, exp tx_valid, exp tx byte
  localparam int NV = 11;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 8'h03, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},  // R2 foreign reboot is global
    {1'b0, 8'hC9, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},  // R2 own report
    {1'b0, 8'hC4, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},  // R2 foreign report ignored
    {1'b0, 8'hA9, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h56},  // R6 ready
    {1'b0, 8'hA9, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA6},  // R6 busy
    {1'b0, 8'hA9, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 8'h5A},  // R6 result waiting
    {1'b0, 8'hAA, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},  // R2 foreign ask ignored
    {1'b1, 8'hA9, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},  // R1 payload in idle ignored
    {1'b0, 8'h22, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},  // R3 long poll arg 2
    {1'b0, 8'h47, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},  // R4 clock-all 7
    {1'b0, 8'h66, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}   // R5 difficulty 6 -> 2
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_valid && !job_reset_o && !reboot_o && !chip_reset_o, "R12 reset outputs", {tx_valid, job_reset_o, reboot_o}, 0);
    chk(lookahead_o == 9'd10, "R12 lookahead reset", lookahead_o, 10);
    chk(difficulty_o == 2'd0 && chip_clk_o == '0, "R12 config reset", difficulty_o, 0);

    for (int v = 0; v < NV; v++) begin
      fifo_nonempty = VEC[v][13];
      job_busy      = VEC[v][12];
      send(VEC[v][22], VEC[v][21:14]);
      chk(reboot_o == VEC[v][11], $sformatf("R2 vec%0d reboot", v), reboot_o, VEC[v][11]);
      chk(job_reset_o == VEC[v][10], $sformatf("R3/R4 vec%0d job_reset", v), job_reset_o, VEC[v][10]);
      chk(report_req_o == VEC[v][9], $sformatf("R2 vec%0d report", v), report_req_o, VEC[v][9]);
      chk(tx_valid == VEC[v][8], $sformatf("R6 vec%0d tx_valid", v), tx_valid, VEC[v][8]);
      if (VEC[v][8]) chk(tx_data == VEC[v][7:0], $sformatf("R6 vec%0d tx_data", v), tx_data, VEC[v][7:0]);
      chk(result_pop_o == (VEC[v][13] && VEC[v][8]), $sformatf("R6 vec%0d result_pop", v), result_pop_o, VEC[v][13]);
    end
    fifo_nonempty = 1'b0; job_busy = 1'b0;
    chk(lookahead_o == 9'd30, "R3 lookahead 10+10*2", lookahead_o, 30);
    chk(difficulty_o == 2'd2, "R5 difficulty low bits", difficulty_o, 2);
    for (int c = 0; c < NCH; c++)
      chk(chip_clk_o[5*c +: 5] == 5'd7, "R4 clock-all value", chip_clk_o[5*c +: 5], 7);
    send(1'b0, 8'h3F);
    chk(lookahead_o == 9'd320 && job_reset_o, "R3 lookahead max arg", lookahead_o, 320);

    // R8 abort mid-job by a command, which is then decoded
    send(1'b0, 8'h89);
    for (int i = 0; i < 3; i++) send(1'b1, 8'hEE);
    send(1'b0, 8'hC9);
    chk(report_req_o && !job_accept_o, "R8 abort decodes new command", report_req_o, 1);
    for (int i = 0; i < JLEN; i++) begin
      send(1'b1, 8'h11);
      chk(!job_accept_o && !tx_valid, "R1 stray payload ignored", job_accept_o, 0);
    end
    // R8 abort by a foreign board command
    send(1'b0, 8'h89);
    send(1'b1, 8'h22);
    send(1'b0, 8'h84);
    send(1'b1, 8'h22);
    chk(!job_accept_o, "R8 foreign command aborts", job_accept_o, 0);

    // R7 full job
    send(1'b0, 8'h89);
    for (int i = 0; i < JLEN; i++) begin
      send(1'b1, 8'(i * 3 + 1));
      if (i < JLEN - 1) chk(!job_accept_o, "R7 no early accept", job_accept_o, 0);
    end
    chk(job_accept_o, "R7 accept pulse", job_accept_o, 1);
    chk(tx_valid && tx_data == 8'h58, "R7 reply 0x58", tx_data, 8'h58);
    for (int i = 0; i < JLEN; i++)
      chk(job_data_o[8*i +: 8] == 8'(i * 3 + 1), "R7 job byte order", job_data_o[8*i +: 8], 8'(i * 3 + 1));

    // R10 mode 1 with masking and fall-through chip reset
    send(1'b0, 8'hE9);
    send(1'b1, 8'h23);
    chk(!chip_reset_o, "R10 no reset before value", chip_reset_o, 0);
    send(1'b1, 8'hFF);
    chk(chip_reset_o && chip_reset_idx_o == 5'd3, "R10 mode1 chip reset", chip_reset_idx_o, 3);
    chk(chip_clk_o[15 +: 5] == 5'd31 && chip_clk_o[10 +: 5] == 5'd7, "R10 mode1 masked write", chip_clk_o[15 +: 5], 31);
    // R10 mode 2
    send(1'b0, 8'hE9);
    send(1'b1, 8'h45);
    chk(chip_reset_o && chip_reset_idx_o == 5'd5, "R10 mode2 chip reset", chip_reset_idx_o, 5);
    chk(chip_clk_o[25 +: 5] == 5'd7 && chip_clk_o[15 +: 5] == 5'd31, "R10 mode2 clocks unchanged", chip_clk_o[25 +: 5], 7);
    send(1'b1, 8'h12);
    chk(chip_clk_o[25 +: 5] == 5'd7 && !chip_reset_o, "R10 mode2 takes no value", chip_clk_o[25 +: 5], 7);

    // R9 mode 0
    send(1'b0, 8'hE9);
    send(1'b1, 8'h00);
    for (int i = 0; i < NCH; i++) begin
      send(1'b1, 8'hE0 | 8'(i));
      chk(job_reset_o == (i == NCH - 1), "R9 job reset after last", job_reset_o, (i == NCH - 1));
    end
    for (int c = 0; c < NCH; c++)
      chk(chip_clk_o[5*c +: 5] == 5'(c), "R9 per-chip order", chip_clk_o[5*c +: 5], c);

    // R11 backpressure
    tx_ready = 1'b0;
    send(1'b0, 8'hA9);
    job_busy = 1'b1;
    send(1'b0, 8'hA9);
    job_busy = 1'b0;
    @(negedge clk);
    chk(tx_valid && tx_data == 8'h56, "R11 stalled head holds", tx_data, 8'h56);
    tx_ready = 1'b1;
    @(negedge clk);
    chk(tx_valid && tx_data == 8'hA6, "R11 second byte in order", tx_data, 8'hA6);
    @(negedge clk);
    chk(!tx_valid, "R11 queue drains", tx_valid, 0);

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule